// File: doc/BRIEF.md
# Power-Good Strap Latch and Output Clock Sequencer

This block decides when the differential outputs of a clock buffer may run and when the oscillator may be on. A single power-good pin has two jobs. Its first rise after reset captures the configuration straps: a frequency select and two three-level address straps. The address straps are decoded into an 8-bit serial-bus device address, which then stays fixed until the next reset. After that first rise, the same pin acts as an asynchronous, active-low power-down request.

When power-down is requested, the block closes every output gate before it drops the oscillator enable. Each gate closes only while its own output clock is low, so no output can emit a shortened pulse. When the pin is released, the oscillator enable comes back first. The outputs return after a programmable settling count of reference cycles.

A change of the frequency-select strap while the outputs run is handled the same glitch-free way: the outputs are gated off, the select is updated, and the outputs are enabled again. Each of these steps starts on a reference-clock edge.

Top module: `pg_clk_seq`

## Requirements
- R1: After reset and before the first power-good rise, `out_en` is all zero, `osc_en` is 0, `dev_addr` is 0x00 and `fsel_out` is 0.
- R2: The power-good pin passes through a two-stage synchronizer. When the pin first rises, `osc_en` goes to 1 after the third reference edge, and not after the second. At that same edge the address straps are decoded into `dev_addr` and the frequency strap is captured into `fsel_out`.
- R3: Each strap code is 2 bits: 00 = low, 01 = mid, 10 = high, and 11 is read as mid. The address is chosen by (upper strap, lower strap): low/low 0xD8, low/mid 0xDA, low/high 0xDE, mid/low 0xC2, mid/mid 0xC4, mid/high 0xC6, high/low 0xCA, high/mid 0xCC, high/high 0xCE.
- R4: Once latched, `dev_addr` ignores any later change of the address straps and any later power-down cycle. Only reset clears it.
- R5: On power-up, `out_en` stays zero for WAIT_CYC reference edges after `osc_en` rises. All bits become 1 on the next edge, which is edge WAIT_CYC+4 after the pin rises when every output clock is low.
- R6: When the pin falls while outputs run, `out_en` clears after the fourth edge and `osc_en` stays 1 until the edge after all `out_en` bits are zero. With all output clocks low, that is the fifth edge.
- R7: An `out_en` bit changes only on a reference edge at which its `out_clk` bit is low. While an output clock is held high, its enable stays where it is, and `osc_en` stays 1.
- R8: When the pin rises again after a power-down, `osc_en` returns after the third edge, and the outputs return WAIT_CYC+1 edges later.
- R9: When the frequency strap changes while outputs run, the following happens and `osc_en` stays 1 throughout:
  - `out_en` clears after the fourth edge.
  - `fsel_out` takes the new value after the fifth edge, while `out_en` is still zero.
  - `out_en` is all ones again after the sixth edge.
- R10: A frequency strap change made while powered down reaches `fsel_out` at the edge where `osc_en` returns, without any gating sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_pin | input | 1 | Power-good on first rise; active-low power-down afterwards (asynchronous) |
| fsel_strap | input | 1 | Frequency select strap (0 = 100 MHz, 1 = 133 MHz) |
| addr_hi_strap | input | 2 | Upper three-level address strap code |
| addr_lo_strap | input | 2 | Lower three-level address strap code |
| out_clk | input | NOUT | Level of each output clock, used to time its gate |
| out_en | output | NOUT | Per-output clock enable |
| osc_en | output | 1 | Oscillator enable |
| dev_addr | output | 8 | Latched serial-bus device address |
| fsel_out | output | 1 | Frequency select in effect |

## Verification
Every result arrives a fixed number of reference edges after its stimulus. The two synchronizer stages plus the state register put `osc_en` three edges after a pin change. The gate register puts `out_en` one edge after that, and the oscillator drop or the new select follows on the next edge. The settling count adds WAIT_CYC edges on power-up. The bench drives inputs on falling edges and counts rising edges explicitly. It samples both one edge before and at the edge where each result is due, so a result that arrives early or late is caught. Held-high output clocks show that a gate waits for its clock to go low and that the oscillator waits for the gate.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OSC_UP,
      ST_RUN,
      ST_DRAIN,
      ST_OFF,
      ST_FSW_DRAIN
   } seq_state_t;

   // strap code to level: 0 low, 1 mid, 2 high (code 3 folds onto mid)
   function automatic logic [1:0] strap_level(input logic [1:0] code);
      return (code == 2'b11) ? 2'd1 : code;
   endfunction

   function automatic logic [7:0] decode_addr(input logic [1:0] hi_code,
                                              input logic [1:0] lo_code);
      logic [1:0] hi;
      logic [1:0] lo;
      hi = strap_level(hi_code);
      lo = strap_level(lo_code);
      unique case ({hi, lo})
         4'h0:    return 8'hD8;
         4'h1:    return 8'hDA;
         4'h2:    return 8'hDE;
         4'h4:    return 8'hC2;
         4'h5:    return 8'hC4;
         4'h6:    return 8'hC6;
         4'h8:    return 8'hCA;
         4'h9:    return 8'hCC;
         default: return 8'hCE;
      endcase
   endfunction

endpackage

// File: rtl/pgseq_sync.sv
module pgseq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pgseq_gate.sv
module pgseq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic want_on,
   input  logic out_clk,
   output logic en
);
   // the enable may only move while the gated clock sits low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en <= 1'b0;
      else if (!out_clk) en <= want_on;
   end
endmodule

// File: rtl/pgseq_fsm.sv
module pgseq_fsm
   import pgseq_pkg::*;
#(
   parameter int WAIT_CYC = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pg_s,
   input  logic       fsel_s,
   input  logic [1:0] hi_code,
   input  logic [1:0] lo_code,
   input  logic       all_off,
   output logic       want_on,
   output logic       osc_en,
   output logic       fsel_q,
   output logic [7:0] addr_q
);
   localparam int CW = $clog2(WAIT_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

   seq_state_t state;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         fsel_q <= 1'b0;
         addr_q <= 8'h00;
      end else begin
         unique case (state)
            ST_IDLE: if (pg_s) begin
               addr_q <= decode_addr(hi_code, lo_code);
               fsel_q <= fsel_s;
               cnt    <= '0;
               state  <= ST_OSC_UP;
            end
            ST_OSC_UP: begin
               if (!pg_s)            state <= ST_OFF;
               else if (cnt == LAST) state <= ST_RUN;
               else                  cnt   <= cnt + 1'b1;
            end
            ST_RUN: begin
               if (!pg_s)                 state <= ST_DRAIN;
               else if (fsel_s != fsel_q) state <= ST_FSW_DRAIN;
            end
            ST_DRAIN: if (all_off) state <= ST_OFF;
            ST_FSW_DRAIN: begin
               if (!pg_s) state <= ST_DRAIN;
               else if (all_off) begin
                  fsel_q <= fsel_s;
                  state  <= ST_RUN;
               end
            end
            ST_OFF: if (pg_s) begin
               fsel_q <= fsel_s;
               cnt    <= '0;
               state  <= ST_OSC_UP;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign want_on = (state == ST_RUN);
   assign osc_en  = (state == ST_OSC_UP) || (state == ST_RUN) ||
                    (state == ST_DRAIN)  || (state == ST_FSW_DRAIN);
endmodule

// File: rtl/pg_clk_seq.sv
module pg_clk_seq #(
   parameter int NOUT        = 12,
   parameter int WAIT_CYC    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            ref_clk,
   input  logic            rst_n,
   input  logic            pg_pin,
   input  logic            fsel_strap,
   input  logic [1:0]      addr_hi_strap,
   input  logic [1:0]      addr_lo_strap,
   input  logic [NOUT-1:0] out_clk,
   output logic [NOUT-1:0] out_en,
   output logic            osc_en,
   output logic [7:0]      dev_addr,
   output logic            fsel_out
);
   if (NOUT < 1) begin : g_bad_nout
      $error("pg_clk_seq: NOUT must be at least 1");
   end
   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("pg_clk_seq: WAIT_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pg_clk_seq: SYNC_STAGES must be at least 2");
   end

   logic [1:0] sync_q;
   logic       want_on;

   pgseq_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (ref_clk),
      .rst_n(rst_n),
      .d    ({fsel_strap, pg_pin}),
      .q    (sync_q)
   );

   pgseq_fsm #(.WAIT_CYC(WAIT_CYC)) i_fsm (
      .clk    (ref_clk),
      .rst_n  (rst_n),
      .pg_s   (sync_q[0]),
      .fsel_s (sync_q[1]),
      .hi_code(addr_hi_strap),
      .lo_code(addr_lo_strap),
      .all_off(out_en == '0),
      .want_on(want_on),
      .osc_en (osc_en),
      .fsel_q (fsel_out),
      .addr_q (dev_addr)
   );

   for (genvar i = 0; i < NOUT; i++) begin : g_gate
      pgseq_gate i_gate (
         .clk    (ref_clk),
         .rst_n  (rst_n),
         .want_on(want_on),
         .out_clk(out_clk[i]),
         .en     (out_en[i])
      );
   end
endmodule

// File: rtl/pg_clk_seq_chk.sv
module pg_clk_seq_chk #(
   parameter int NOUT = 12
) (
   input logic            ref_clk,
   input logic            rst_n,
   input logic [NOUT-1:0] out_clk,
   input logic [NOUT-1:0] out_en,
   input logic            osc_en,
   input logic [7:0]      dev_addr,
   input logic            fsel_out
);
   // R6
   osc_after_gates_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(osc_en) |-> (out_en == '0));

   // R5
   gates_need_osc_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (out_en != '0) |-> osc_en);

   // R4
   addr_frozen_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (dev_addr != 8'h00) |=> $stable(dev_addr));

   // R9
   fsel_gated_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (fsel_out != $past(fsel_out)) |-> (out_en == '0));

   for (genvar i = 0; i < NOUT; i++) begin : g_bit
      // R7
      gate_on_low_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
         (out_en[i] != $past(out_en[i])) |-> !$past(out_clk[i]));
   end
endmodule

bind pg_clk_seq pg_clk_seq_chk #(.NOUT(NOUT)) i_pg_clk_seq_chk (
   .ref_clk (ref_clk),
   .rst_n   (rst_n),
   .out_clk (out_clk),
   .out_en  (out_en),
   .osc_en  (osc_en),
   .dev_addr(dev_addr),
   .fsel_out(fsel_out)
);

// File: tb/test_pg_clk_seq.sv
module test_pg_clk_seq;
   localparam int NOUT = 12;
   localparam int WAIT = 16;
   localparam logic [NOUT-1:0] ALL = {NOUT{1'b1}};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pg = 1'b0;
   logic            fsel = 1'b0;
   logic [1:0]      sa_hi = 2'b00;
   logic [1:0]      sa_lo = 2'b00;
   logic [NOUT-1:0] oclk = '0;
   logic [NOUT-1:0] out_en;
   logic            osc_en;
   logic [7:0]      dev_addr;
   logic            fsel_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   pg_clk_seq #(.NOUT(NOUT), .WAIT_CYC(WAIT)) i_pg_clk_seq (
      .ref_clk(clk), .rst_n(rst_n), .pg_pin(pg), .fsel_strap(fsel),
      .addr_hi_strap(sa_hi), .addr_lo_strap(sa_lo), .out_clk(oclk),
      .out_en(out_en), .osc_en(osc_en), .dev_addr(dev_addr), .fsel_out(fsel_out)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [7:0] exp_addr(input logic [1:0] h, input logic [1:0] l);
      int hl;
      int ll;
      logic [7:0] tbl [9];
      tbl = '{8'hD8, 8'hDA, 8'hDE, 8'hC2, 8'hC4, 8'hC6, 8'hCA, 8'hCC, 8'hCE};
      hl = (h == 2'b11) ? 1 : int'(h);
      ll = (l == 2'b11) ? 1 : int'(l);
      return tbl[hl * 3 + ll];
   endfunction

   task automatic do_reset(input logic [1:0] h, input logic [1:0] l, input logic f);
      @(negedge clk);
      rst_n = 1'b0; pg = 1'b0; oclk = '0;
      sa_hi = h; sa_lo = l; fsel = f;
      tick(2);
      rst_n = 1'b1;
      tick(2);
   endtask

   task automatic power_up_running();
      pg = 1'b1;
      tick(WAIT + 4);
   endtask

   task automatic t_reset();
      do_reset(2'b01, 2'b10, 1'b1);
      check("R1 out_en", 32'(out_en), 32'h0);
      check("R1 osc_en", 32'(osc_en), 32'h0);
      check("R1 dev_addr", 32'(dev_addr), 32'h0);
      check("R1 fsel_out", 32'(fsel_out), 32'h0);
   endtask

   task automatic t_powerup();
      do_reset(2'b10, 2'b01, 1'b1);
      pg = 1'b1;
      tick(2);
      check("R2 osc_en after 2 edges", 32'(osc_en), 32'h0);
      tick(1);
      check("R2 osc_en after 3 edges", 32'(osc_en), 32'h1);
      check("R2 dev_addr latched", 32'(dev_addr), 32'hCC);
      check("R2 fsel_out latched", 32'(fsel_out), 32'h1);
      tick(WAIT);
      check("R5 out_en before settle", 32'(out_en), 32'h0);
      tick(1);
      check("R5 out_en after settle", 32'(out_en), 32'(ALL));
   endtask

   task automatic t_addr_map();
      for (int h = 0; h < 4; h++) begin
         for (int l = 0; l < 4; l++) begin
            do_reset(2'(h), 2'(l), 1'b0);
            pg = 1'b1;
            tick(3);
            check("R3 address decode", 32'(dev_addr), 32'(exp_addr(2'(h), 2'(l))));
         end
      end
   endtask

   task automatic t_strap_ignore();
      do_reset(2'b00, 2'b00, 1'b0);
      power_up_running();
      sa_hi = 2'b10; sa_lo = 2'b10;
      tick(10);
      check("R4 straps ignored while running", 32'(dev_addr), 32'hD8);
      pg = 1'b0;
      tick(8);
      pg = 1'b1;
      tick(WAIT + 4);
      check("R4 straps ignored after power cycle", 32'(dev_addr), 32'hD8);
   endtask

   task automatic t_powerdown();
      do_reset(2'b01, 2'b01, 1'b0);
      power_up_running();
      pg = 1'b0;
      tick(3);
      check("R6 out_en after 3 edges", 32'(out_en), 32'(ALL));
      tick(1);
      check("R6 out_en cleared", 32'(out_en), 32'h0);
      check("R6 osc_en still on", 32'(osc_en), 32'h1);
      tick(1);
      check("R6 osc_en dropped", 32'(osc_en), 32'h0);
      pg = 1'b1;
      tick(3);
      check("R8 osc_en back", 32'(osc_en), 32'h1);
      check("R8 out_en still off", 32'(out_en), 32'h0);
      tick(WAIT);
      check("R8 out_en before settle", 32'(out_en), 32'h0);
      tick(1);
      check("R8 out_en restored", 32'(out_en), 32'(ALL));
   endtask

   task automatic t_gate_hold();
      do_reset(2'b00, 2'b01, 1'b0);
      power_up_running();
      oclk[3] = 1'b1;
      pg = 1'b0;
      tick(4);
      check("R7 held clock keeps its gate", 32'(out_en), 32'h8);
      tick(6);
      check("R7 gate still held", 32'(out_en), 32'h8);
      check("R7 osc_en waits for gate", 32'(osc_en), 32'h1);
      oclk[3] = 1'b0;
      tick(1);
      check("R7 gate closes on low clock", 32'(out_en), 32'h0);
      tick(1);
      check("R7 osc_en drops after gate", 32'(osc_en), 32'h0);
   endtask

   task automatic t_fsw();
      do_reset(2'b00, 2'b10, 1'b0);
      power_up_running();
      fsel = 1'b1;
      tick(3);
      check("R9 out_en before switch", 32'(out_en), 32'(ALL));
      tick(1);
      check("R9 outputs gated", 32'(out_en), 32'h0);
      check("R9 old select held", 32'(fsel_out), 32'h0);
      tick(1);
      check("R9 new select", 32'(fsel_out), 32'h1);
      check("R9 outputs still gated", 32'(out_en), 32'h0);
      check("R9 osc_en kept", 32'(osc_en), 32'h1);
      tick(1);
      check("R9 outputs re-enabled", 32'(out_en), 32'(ALL));
   endtask

   task automatic t_fsel_off();
      do_reset(2'b10, 2'b10, 1'b1);
      power_up_running();
      pg = 1'b0;
      tick(8);
      fsel = 1'b0;
      tick(4);
      check("R10 select unchanged while off", 32'(fsel_out), 32'h1);
      pg = 1'b1;
      tick(3);
      check("R10 select taken on resume", 32'(fsel_out), 32'h0);
      check("R10 osc_en on resume", 32'(osc_en), 32'h1);
   endtask

   initial begin
      t_reset();
      t_powerup();
      t_addr_map();
      t_strap_ignore();
      t_powerdown();
      t_gate_hold();
      t_fsw();
      t_fsel_off();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule